// File: doc/BRIEF.md
# Message-Signalled Interrupt Address Generator

This block turns interrupt events into single 32-bit memory writes for a message-signalled interrupt controller. It holds two address configuration pairs, one for the machine level and one for the supervisor level. Each pair has a low word with the bottom 32 bits of a base page number. It also has an upper word holding the top 12 base bits, a lock flag and four fields that place a hart index inside the page number. A per-source target word names the destination hart, the guest interrupt file and the interrupt identity. A source is numbered 1 to `NUM_SRC`, and source number 0 does not exist.

A source becomes pending when its trigger input pulses. It is turned into a message when the domain enable is high, the source is enabled and the source is pending. Software can also ask for one message directly through a generate-message register. Every message leaves as one request on a valid/ready handshake. The request carries a 64-bit byte address and a 32-bit data word that holds the identity. A domain instantiated at machine level uses the machine pair and always sends guest index 0. A supervisor domain uses the supervisor pair.

Top module: `msi_addr_gen`

## Requirements
- R1: After synchronous reset every register reads 0, no source is pending and `msg_valid` is low.
- R2: A write to an upper address word keeps only bit 31 (lock), bits 28:24 (group shift), bits 22:20 (hart shift), bits 18:16 (group width), bits 15:12 (hart width) and bits 11:0 (top of base). Every other bit reads 0, so writing all ones reads back 32'h9F77_FFFF.
- R3: Once bit 31 of the machine upper word is 1, writes to all four address words have no effect until reset.
- R4: A target word keeps hart index in bits 31:18, guest index in bits 17:12 and identity in bits 10:0, with bit 11 reading 0. The address of a source message is computed in steps. The group part (hart >> hart width, masked to group width) is shifted left by group shift + 12. The local part (hart masked to hart width) is shifted left by hart shift. The guest index is masked to 2^hart shift − 1. These three terms are OR-ed with the 44-bit base, and the result is shifted left by 12.
- R5: A machine-level instance forms addresses from the machine pair and uses guest index 0 whatever the target word holds.
- R6: A write to the generate register (select 4) requests one message with hart index = value >> 18, guest 0 and identity = value[10:0], regardless of the domain enable. Reading the register returns the written value with bits 17:12 cleared.
- R7: A source message is issued only when `intr_en`, the source's enable and its pending bit are all 1. A trigger pulse sets the pending bit even when the message is blocked.
- R8: While `msg_valid` is high and `msg_ready` is low, the address and data hold steady and the source's pending bit stays 1. The pending bit clears on the accepting edge.
- R9: Among ready sources the lowest-numbered one is sent first. Exactly one message leaves per accepted handshake, and `msg_valid` is low for the cycle after each acceptance.
- R10: A requested generate message is loaded before any pending source message.
- R11: The data word carries the 11-bit identity in bits 10:0 with bits 31:11 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 machine low, 1 machine upper, 2 supervisor low, 3 supervisor upper, 4 generate, 5 target |
| reg_idx | input | SRC_W | Source number for target access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| intr_en | input | 1 | Domain interrupt enable |
| src_trig | input | NUM_SRC | Per-source trigger pulse (bit k−1 for source k) |
| src_en | input | NUM_SRC | Per-source enable |
| src_pend | output | NUM_SRC | Per-source pending bits |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 64 | Byte address of the message write |
| msg_data | output | 32 | Data of the message write |

## Verification
The hardest situation to create is a source trigger and a generate-message request in the same cycle. The ordering between them is decided only in that one cycle. The bench holds the handshake ready low and, in one cycle, pulses a source trigger and writes the generate register. It then watches which message appears first. A second hard case is several sources becoming pending together while the output is busy. The bench triggers three sources in one cycle and drains them one handshake at a time to confirm the order.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam int PAGE_SHIFT = 12;
    localparam int HART_W     = 14;
    localparam int GUEST_W    = 6;
    localparam int IID_W      = 11;

    localparam logic [31:0] HI_KEEP  = 32'h9F77_FFFF;
    localparam logic [31:0] GEN_KEEP = 32'hFFFC_0FFF;
    localparam logic [31:0] TGT_KEEP = 32'hFFFF_F7FF;

    typedef enum logic [2:0] {
        SEL_M_LO = 3'd0,
        SEL_M_HI = 3'd1,
        SEL_S_LO = 3'd2,
        SEL_S_HI = 3'd3,
        SEL_GEN  = 3'd4,
        SEL_TGT  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsv_a;
        logic [4:0] grp_shift;
        logic       rsv_b;
        logic [2:0] hart_shift;
        logic       rsv_c;
        logic [2:0] grp_width;
        logic [3:0] hart_width;
        logic [11:0] base_top;
    } addr_hi_t;

    typedef struct packed {
        logic [HART_W-1:0]  hart;
        logic [GUEST_W-1:0] guest;
        logic               rsv;
        logic [IID_W-1:0]   iid;
    } target_t;

    function automatic logic [63:0] low_mask(input int unsigned width);
        return (64'd1 << width) - 64'd1;
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] m_lo,
    output addr_hi_t    m_hi,
    output logic [31:0] s_lo,
    output addr_hi_t    s_hi
);

    logic locked;
    assign locked = m_hi.lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_lo <= '0;
            m_hi <= '0;
            s_lo <= '0;
            s_hi <= '0;
        end else if (wr_en && !locked) begin
            case (reg_sel_e'(wr_sel))
                SEL_M_LO: m_lo <= wr_data;
                SEL_M_HI: m_hi <= addr_hi_t'(wr_data & HI_KEEP);
                SEL_S_LO: s_lo <= wr_data;
                SEL_S_HI: s_hi <= addr_hi_t'(wr_data & HI_KEEP);
                default: ;
            endcase
        end
    end

    // R3: lock never drops and freezes every address word
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        m_hi.lock |=> m_hi.lock);
    p_lock_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        m_hi.lock |=> ($stable(m_lo) && $stable(s_lo) && $stable(s_hi)));

endmodule

// File: rtl/msi_addr_calc.sv
module msi_addr_calc
    import msi_pkg::*;
(
    input  logic [31:0]        base_lo,
    input  addr_hi_t           cfg_hi,
    input  logic [HART_W-1:0]  hart,
    input  logic [GUEST_W-1:0] guest,
    output logic [63:0]        addr
);

    logic [63:0] hart_ext;
    logic [63:0] grp_term;
    logic [63:0] loc_term;
    logic [63:0] gst_term;
    logic [63:0] base_term;
    logic [63:0] ppn;

    always_comb begin
        hart_ext  = {{(64-HART_W){1'b0}}, hart};
        base_term = {20'b0, cfg_hi.base_top, base_lo};
        grp_term  = (hart_ext >> cfg_hi.hart_width) & low_mask(32'(cfg_hi.grp_width));
        grp_term  = grp_term << (32'(cfg_hi.grp_shift) + PAGE_SHIFT);
        loc_term  = (hart_ext & low_mask(32'(cfg_hi.hart_width))) << cfg_hi.hart_shift;
        gst_term  = {{(64-GUEST_W){1'b0}}, guest} & low_mask(32'(cfg_hi.hart_shift));
        ppn       = base_term | grp_term | loc_term | gst_term;
        addr      = ppn << PAGE_SHIFT;
    end

endmodule

// File: rtl/msi_src_table.sv
module msi_src_table
    import msi_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tgt_wr,
    input  logic [SRC_W-1:0]   tgt_idx,
    input  logic [31:0]        tgt_data,
    input  logic [NUM_SRC:1]   trig,
    input  logic [NUM_SRC:1]   en,
    input  logic               intr_en,
    input  logic               clr_en,
    input  logic [SRC_W-1:0]   clr_idx,
    output logic [31:0]        rd_target,
    output logic [NUM_SRC:1]   pend,
    output logic               pick_valid,
    output logic [SRC_W-1:0]   pick_idx,
    output target_t            pick_tgt
);

    target_t            tgt_q [1:NUM_SRC];
    logic [NUM_SRC:1]   ready_vec;
    logic [NUM_SRC:1]   grant;

    for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i]  <= 1'b0;
                tgt_q[i] <= '0;
            end else begin
                if (trig[i]) begin
                    pend[i] <= 1'b1;
                end else if (clr_en && clr_idx == SRC_W'(i)) begin
                    pend[i] <= 1'b0;
                end
                if (tgt_wr && tgt_idx == SRC_W'(i)) begin
                    tgt_q[i] <= target_t'(tgt_data & TGT_KEEP);
                end
            end
        end

        // R7: a trigger always leaves the source pending
        p_trig_sets_r7: assert property (@(posedge clk) disable iff (rst)
            trig[i] |=> pend[i]);
    end

    assign ready_vec = pend & en & {NUM_SRC{intr_en}};

    always_comb begin
        grant      = '0;
        pick_valid = 1'b0;
        pick_idx   = '0;
        pick_tgt   = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (ready_vec[i] && !pick_valid) begin
                grant[i]   = 1'b1;
                pick_valid = 1'b1;
                pick_idx   = SRC_W'(i);
                pick_tgt   = tgt_q[i];
            end
        end
    end

    always_comb begin
        rd_target = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (tgt_idx == SRC_W'(i)) begin
                rd_target = tgt_q[i];
            end
        end
    end

    // R9: at most one source is granted per cycle
    p_grant_single_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/msi_addr_gen.sv
module msi_addr_gen
    import msi_pkg::*;
#(
    parameter int  NUM_SRC       = 8,
    parameter bit  MACHINE_LEVEL = 1'b0,
    localparam int SRC_W         = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [2:0]         reg_sel,
    input  logic [SRC_W-1:0]   reg_idx,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               intr_en,
    input  logic [NUM_SRC:1]   src_trig,
    input  logic [NUM_SRC:1]   src_en,
    output logic [NUM_SRC:1]   src_pend,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);

    logic [31:0]        m_lo, s_lo, use_lo;
    addr_hi_t           m_hi, s_hi, use_hi;
    logic [31:0]        gen_q;
    logic               gen_pend;
    logic [31:0]        rd_target;
    logic               pick_valid;
    logic [SRC_W-1:0]   pick_idx;
    target_t            pick_tgt;
    logic               clr_en;
    logic               load;
    logic [HART_W-1:0]  nxt_hart;
    logic [GUEST_W-1:0] nxt_guest;
    logic [IID_W-1:0]   nxt_iid;
    logic [63:0]        nxt_addr;
    logic               q_is_src;
    logic [SRC_W-1:0]   q_src;

    msi_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .m_lo    (m_lo),
        .m_hi    (m_hi),
        .s_lo    (s_lo),
        .s_hi    (s_hi)
    );

    msi_src_table #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .tgt_wr     (reg_wr && reg_sel_e'(reg_sel) == SEL_TGT),
        .tgt_idx    (reg_idx),
        .tgt_data   (reg_wdata),
        .trig       (src_trig),
        .en         (src_en),
        .intr_en    (intr_en),
        .clr_en     (clr_en),
        .clr_idx    (q_src),
        .rd_target  (rd_target),
        .pend       (src_pend),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .pick_tgt   (pick_tgt)
    );

    if (MACHINE_LEVEL) begin : g_mach
        assign use_lo = m_lo;
        assign use_hi = m_hi;
    end else begin : g_super
        assign use_lo = s_lo;
        assign use_hi = s_hi;
    end

    always_comb begin
        if (gen_pend) begin
            nxt_hart  = gen_q[31:32-HART_W];
            nxt_guest = '0;
            nxt_iid   = gen_q[IID_W-1:0];
        end else begin
            nxt_hart  = pick_tgt.hart;
            nxt_guest = MACHINE_LEVEL ? '0 : pick_tgt.guest;
            nxt_iid   = pick_tgt.iid;
        end
    end

    msi_addr_calc u_calc (
        .base_lo (use_lo),
        .cfg_hi  (use_hi),
        .hart    (nxt_hart),
        .guest   (nxt_guest),
        .addr    (nxt_addr)
    );

    assign load   = !msg_valid && (gen_pend || pick_valid);
    assign clr_en = msg_valid && msg_ready && q_is_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q    <= '0;
            gen_pend <= 1'b0;
        end else if (reg_wr && reg_sel_e'(reg_sel) == SEL_GEN) begin
            gen_q    <= reg_wdata & GEN_KEEP;
            gen_pend <= 1'b1;
        end else if (load && gen_pend) begin
            gen_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
            q_is_src  <= 1'b0;
            q_src     <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_addr  <= nxt_addr;
            msg_data  <= {{(32-IID_W){1'b0}}, nxt_iid};
            q_is_src  <= !gen_pend;
            q_src     <= gen_pend ? '0 : pick_idx;
        end else if (msg_valid && msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_M_LO: reg_rdata = m_lo;
            SEL_M_HI: reg_rdata = m_hi;
            SEL_S_LO: reg_rdata = s_lo;
            SEL_S_HI: reg_rdata = s_hi;
            SEL_GEN:  reg_rdata = gen_q;
            SEL_TGT:  reg_rdata = rd_target;
            default:  reg_rdata = '0;
        endcase
    end

    // R8: a stalled request holds still and keeps its source pending
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
    p_pend_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready && q_is_src) |=> src_pend[q_src]);
    // R9: one message per accepted handshake
    p_one_per_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=> !msg_valid);
    // R7: a source message needs the domain enable
    p_src_needs_ie_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(msg_valid) && q_is_src) |-> $past(intr_en));
    // R10: a source message never overtakes a waiting generate request
    p_gen_first_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(msg_valid) && q_is_src) |-> !$past(gen_pend));

endmodule

// File: tb/msi_addr_gen_bench.sv
module msi_addr_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;

    localparam logic [31:0] VEC_LO [4] = '{32'h0008_0000, 32'h0010_0000, 32'h0000_0000, 32'h2000_0000};
    localparam logic [31:0] VEC_HI [4] = '{32'h0000_0000, 32'h0030_2000, 32'h0402_1001, 32'h0241_3000};
    localparam logic [13:0] VEC_HART [4] = '{14'd5, 14'd6, 14'd7, 14'h3FFF};
    localparam logic [5:0]  VEC_GUEST [4] = '{6'd3, 6'd5, 6'd9, 6'h3F};
    localparam logic [10:0] VEC_IID [4] = '{11'h021, 11'h7FF, 11'h155, 11'h001};
    localparam logic [63:0] VEC_ADDR [4] = '{64'h0000_0000_8000_0000, 64'h0000_0001_0001_5000,
                                              64'h0000_1000_3000_1000, 64'h0000_0200_0407_F000};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic        intr_en = 1'b0;
    logic [NSRC:1] src_trig = '0;
    logic [NSRC:1] src_en = '0;
    logic        msg_ready = 1'b0;

    logic [31:0] rdata, rdata_m;
    logic [NSRC:1] pend, pend_m;
    logic        valid, valid_m;
    logic [63:0] addr, addr_m;
    logic [31:0] data, data_m;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_addr_gen #(.NUM_SRC(NSRC), .MACHINE_LEVEL(1'b0)) u_msi_addr_gen (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .intr_en(intr_en), .src_trig(src_trig),
        .src_en(src_en), .src_pend(pend), .msg_valid(valid), .msg_ready(msg_ready),
        .msg_addr(addr), .msg_data(data)
    );

    msi_addr_gen #(.NUM_SRC(NSRC), .MACHINE_LEVEL(1'b1)) u_msi_addr_gen_m (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_m), .intr_en(intr_en), .src_trig(src_trig),
        .src_en(src_en), .src_pend(pend_m), .msg_valid(valid_m), .msg_ready(msg_ready),
        .msg_addr(addr_m), .msg_data(data_m)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, input logic [3:0] idx, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel; reg_idx = idx;
        #1 val = rdata;
    endtask

    task automatic pulse(input logic [NSRC:1] mask);
        @(negedge clk);
        src_trig = mask;
        @(negedge clk);
        src_trig = '0;
    endtask

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 8; n++) begin
            if (valid) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    function automatic logic [31:0] tgt_word(input logic [13:0] h, input logic [5:0] g, input logic [10:0] i);
        return {h, g, 1'b0, i};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [63:0] held;
        bit ok;
        logic [10:0] order [3];

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        chk("R1 valid", 64'(valid), 64'd0);
        chk("R1 pend", 64'(pend), 64'd0);
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), 4'd0, r);
            chk("R1 reg", 64'(r), 64'd0);
        end
        rd(3'd5, 4'd3, r);
        chk("R1 target", 64'(r), 64'd0);

        // machine pair used by the machine-level instance
        wr(3'd0, 4'd0, 32'h0010_0000);
        wr(3'd1, 4'd0, 32'h0030_2000);
        intr_en = 1'b1;
        src_en = '1;

        // R4/R11/R5: table of address vectors
        for (int v = 0; v < 4; v++) begin
            wr(3'd2, 4'd0, VEC_LO[v]);
            wr(3'd3, 4'd0, VEC_HI[v]);
            wr(3'd5, 4'd1, tgt_word(VEC_HART[v], VEC_GUEST[v], VEC_IID[v]));
            pulse(8'h01);
            wait_valid(ok);
            chk("R4 valid", 64'(ok), 64'd1);
            chk("R4 addr", addr, VEC_ADDR[v]);
            chk("R11 data", 64'(data), {53'd0, VEC_IID[v]});
            if (v == 1) chk("R5 machine addr guest0", addr_m, 64'h0000_0001_0001_0000);
            accept();
            chk("R8 pend cleared", 64'(pend[1]), 64'd0);
            chk("R9 valid low after accept", 64'(valid), 64'd0);
        end

        // R4: target word field masking
        wr(3'd5, 4'd6, 32'hFFFF_FFFF);
        rd(3'd5, 4'd6, r);
        chk("R4 target readback", 64'(r), 64'h0000_0000_FFFF_F7FF);

        // R7: domain enable off, then source disabled
        intr_en = 1'b0;
        pulse(8'h01);
        repeat (5) @(negedge clk);
        chk("R7 no msg without intr_en", 64'(valid), 64'd0);
        chk("R7 pend kept", 64'(pend[1]), 64'd1);
        src_en[1] = 1'b0;
        intr_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 no msg when disabled", 64'(valid), 64'd0);
        src_en[1] = 1'b1;
        wait_valid(ok);
        chk("R7 msg after enable", 64'(ok), 64'd1);
        accept();

        // R8: stall holds request
        pulse(8'h01);
        wait_valid(ok);
        held = addr;
        repeat (4) @(negedge clk);
        chk("R8 valid held", 64'(valid), 64'd1);
        chk("R8 addr stable", addr, held);
        chk("R8 pend during stall", 64'(pend[1]), 64'd1);
        accept();
        chk("R8 pend after accept", 64'(pend[1]), 64'd0);

        // R9: lowest number first
        wr(3'd5, 4'd2, tgt_word(14'd0, 6'd0, 11'h102));
        wr(3'd5, 4'd3, tgt_word(14'd0, 6'd0, 11'h103));
        wr(3'd5, 4'd5, tgt_word(14'd0, 6'd0, 11'h105));
        order = '{11'h102, 11'h103, 11'h105};
        pulse(8'h16);
        for (int k = 0; k < 3; k++) begin
            wait_valid(ok);
            chk("R9 order", 64'(data), {53'd0, order[k]});
            accept();
            chk("R9 one per handshake", 64'(valid), 64'd0);
        end

        // R6/R10: generate register vs pending source in the same cycle
        wr(3'd2, 4'd0, 32'h0010_0000);
        wr(3'd3, 4'd0, 32'h0030_2000);
        wr(3'd5, 4'd4, tgt_word(14'd0, 6'd0, 11'h104));
        @(negedge clk);
        src_trig = 8'h08;
        reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h0014_5ABC;
        @(negedge clk);
        src_trig = '0; reg_wr = 1'b0;
        wait_valid(ok);
        chk("R10 gen first", 64'(data), 64'h2BC);
        chk("R6 gen addr", addr, 64'h0000_0001_0000_8000);
        chk("R6 gen addr machine", addr_m, 64'h0000_0001_0000_8000);
        accept();
        wait_valid(ok);
        chk("R10 source after gen", 64'(data), 64'h104);
        accept();
        rd(3'd4, 4'd0, r);
        chk("R6 gen readback", 64'(r), 64'h0000_0000_0014_0ABC);

        // R6: generate ignores domain enable
        intr_en = 1'b0;
        wr(3'd4, 4'd0, 32'h0004_0001);
        wait_valid(ok);
        chk("R6 gen without intr_en", 64'(ok), 64'd1);
        chk("R6 gen data", 64'(data), 64'd1);
        accept();
        intr_en = 1'b1;

        // R2: upper word masking
        wr(3'd3, 4'd0, 32'hFFFF_FFFF);
        rd(3'd3, 4'd0, r);
        chk("R2 hi mask", 64'(r), 64'h0000_0000_9F77_FFFF);

        // R3: lock
        wr(3'd1, 4'd0, 32'h8030_2000);
        rd(3'd1, 4'd0, r);
        chk("R3 lock set", 64'(r), 64'h0000_0000_8030_2000);
        wr(3'd0, 4'd0, 32'h0000_1234);
        rd(3'd0, 4'd0, r);
        chk("R3 m_lo frozen", 64'(r), 64'h0000_0000_0010_0000);
        wr(3'd2, 4'd0, 32'h0000_5555);
        rd(3'd2, 4'd0, r);
        chk("R3 s_lo frozen", 64'(r), 64'h0000_0000_0010_0000);
        wr(3'd3, 4'd0, 32'h0000_0000);
        rd(3'd3, 4'd0, r);
        chk("R3 s_hi frozen", 64'(r), 64'h0000_0000_9F77_FFFF);
        wr(3'd1, 4'd0, 32'h0000_0000);
        rd(3'd1, 4'd0, r);
        chk("R3 lock sticky", 64'(r), 64'h0000_0000_8030_2000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule